// File: doc/BRIEF.md
# Periodic Interrupt Timer with Mask and Flag Registers

This block produces a steady periodic timeout from a clock-enable input and latches each timeout in a sticky flag. It holds an 8-bit enable register and an 8-bit flag register. Bits that have the same position in the two registers belong together. Three more flag bits are set by single-cycle pulses from neighbouring timer logic. The interrupt output is high while any flag is set together with its enable bit.

Each period is counted from the previous timeout. Clearing the flag does not restart the count, so the interrupt rate does not drift with software service time. A 2-bit rate field in the enable register sets the period to 2^13, 2^14, 2^15 or 2^16 clock-enable ticks. Software reads either register over a small synchronous bus. It clears flags by writing ones to their positions.

Top module: `pit_top`

## Requirements
- R1: Address 0 is the enable register. Bit 7 enables the overflow flag, bit 6 the periodic flag, bit 5 the accumulator-overflow flag and bit 4 the accumulator-edge flag. Bits 1:0 are the rate field. Bits 3:2 ignore writes and always read 0, so writing 8'hFF reads back 8'hF3.
- R2: After reset, the enable register reads 8'h00, the flag register reads 8'h00 and `irq` is 0.
- R3: With the rate field at 0 and a tick on every cycle from reset, flag bit 6 is still 0 after 8191 ticks and reads 1 after the 8192nd tick.
- R4: Later timeouts fall exactly one period after the previous timeout (ticks 16384, 24576, ...), wherever the flag was cleared inside the period.
- R5: The period counter advances only in cycles with `tickEn` high. Cycles without a tick do not move the timeout.
- R6: A timeout sets flag bit 6 even when enable bit 6 is 0.
- R7: Address 1 is the flag register. Writing 1 to a flag position clears that flag. Writing 0 leaves it unchanged. Bits 3:0 of the flag register always read 0.
- R8: A one-cycle pulse on `ovfSet`, `accOvfSet` or `accEdgeSet` sets flag bit 7, 5 or 4 respectively.
- R9: `irq` is the OR over bits 7:4 of (flag AND enable). It follows the registers with no added delay.
- R10: If a timeout and a clearing write to flag bit 6 happen in the same cycle, the flag ends up set.
- R11: Rate values 1, 2 and 3 give first timeouts after 16384, 32768 and 65536 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Clock enable; one period tick per high cycle |
| busSel | input | 1 | Bus access select |
| busWr | input | 1 | Write strobe, taken at the clock edge when busSel is high |
| busAddr | input | 1 | 0 = enable register, 1 = flag register |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr, combinational |
| ovfSet | input | 1 | Set pulse for flag bit 7 |
| accOvfSet | input | 1 | Set pulse for flag bit 5 |
| accEdgeSet | input | 1 | Set pulse for flag bit 4 |
| irq | output | 1 | Interrupt request |

## Verification
A write, a set pulse or a timeout takes effect at the clock edge that samples it. The new register value then shows on `busRdata` and `irq` in the same cycle, with no further latency. The Nth tick after reset is the Nth rising edge at which `tickEn` is high. The bench drives inputs on falling edges and counts the ticks it has given. It samples on the falling edge just after the edge that is due to produce a result, and also on the falling edge one tick before that, so an off-by-one period is caught. For the collision case, the clearing write is placed on the exact edge where the tick count completes the period.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int DATA_W    = 8;
  localparam int BIT_TOVF  = 7;
  localparam int BIT_RTI   = 6;
  localparam int BIT_AOVF  = 5;
  localparam int BIT_AEDGE = 4;
  localparam logic [DATA_W-1:0] MASK_IMPL = 8'hF3;
  localparam logic [DATA_W-1:0] FLAG_IMPL = 8'hF0;

  typedef struct packed {
    logic              maskWe;
    logic [DATA_W-1:0] maskData;
    logic [DATA_W-1:0] clrBits;
    logic [DATA_W-1:0] setBits;
  } pit_strobe_t;
endpackage

// File: rtl/pit_period_counter.sv
module pit_period_counter #(
  parameter int BASE_EXP = 13,
  parameter int RATE_W   = 2,
  localparam int NUM_RATES = 1 << RATE_W,
  localparam int CNT_W     = BASE_EXP + NUM_RATES - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [RATE_W-1:0] rateSel,
  output logic              timeout,
  output logic [CNT_W-1:0]  countOut
);
  logic [CNT_W-1:0]     countQ;
  logic [NUM_RATES-1:0] lowOnes;

  // Free-running count: the next period starts at the timeout itself.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       countQ <= '0;
    else if (tickEn) countQ <= countQ + 1'b1;
  end

  for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate
    assign lowOnes[r] = &countQ[BASE_EXP+r-1:0];
  end

  assign timeout  = tickEn & lowOnes[rateSel];
  assign countOut = countQ;
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              timeout,
  input  logic              ovfSet,
  input  logic              accOvfSet,
  input  logic              accEdgeSet,
  output pit_strobe_t       strobe
);
  logic wrAccess;
  assign wrAccess = busSel & busWr;

  always_comb begin
    strobe          = '0;
    strobe.maskWe   = wrAccess & ~busAddr;
    strobe.maskData = busWdata & MASK_IMPL;
    if (wrAccess && busAddr) strobe.clrBits = busWdata & FLAG_IMPL;
    strobe.setBits[BIT_TOVF]  = ovfSet;
    strobe.setBits[BIT_RTI]   = timeout;
    strobe.setBits[BIT_AOVF]  = accOvfSet;
    strobe.setBits[BIT_AEDGE] = accEdgeSet;
  end
endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  pit_strobe_t       strobe,
  input  logic              busAddr,
  output logic [DATA_W-1:0] busRdata,
  output logic [RATE_W-1:0] rateSel,
  output logic [DATA_W-1:0] flagsOut,
  output logic              irq
);
  logic [DATA_W-1:0] maskQ;
  logic [DATA_W-1:0] flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskQ <= '0;
    else if (strobe.maskWe) maskQ <= strobe.maskData;
  end

  // Set is OR-ed after the clear, so a coincident set wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= ((flagQ & ~strobe.clrBits) | strobe.setBits) & FLAG_IMPL;
  end

  assign busRdata = busAddr ? flagQ : maskQ;
  assign rateSel  = maskQ[RATE_W-1:0];
  assign flagsOut = flagQ;
  assign irq      = |(flagQ & maskQ & FLAG_IMPL);
endmodule

// File: rtl/pit_top.sv
module pit_top
  import pit_pkg::*;
#(
  parameter int BASE_EXP = 13,
  parameter int RATE_W   = 2,
  localparam int CNT_W   = BASE_EXP + (1 << RATE_W) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              ovfSet,
  input  logic              accOvfSet,
  input  logic              accEdgeSet,
  output logic              irq
);
  pit_strobe_t       strobe;
  logic              timeoutPulse;
  logic [RATE_W-1:0] rateSel;
  logic [CNT_W-1:0]  periodCount;
  logic [DATA_W-1:0] flagBits;

  pit_period_counter #(.BASE_EXP(BASE_EXP), .RATE_W(RATE_W)) counter_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rateSel(rateSel),
    .timeout(timeoutPulse), .countOut(periodCount)
  );

  pit_ctrl ctrl_i (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .timeout(timeoutPulse), .ovfSet(ovfSet), .accOvfSet(accOvfSet),
    .accEdgeSet(accEdgeSet), .strobe(strobe)
  );

  pit_datapath #(.RATE_W(RATE_W)) datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busAddr(busAddr),
    .busRdata(busRdata), .rateSel(rateSel), .flagsOut(flagBits), .irq(irq)
  );
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             busSel,
  input logic             busWr,
  input logic             busAddr,
  input logic [7:0]       busWdata,
  input logic [7:0]       busRdata,
  input logic [7:0]       flagBits,
  input logic [CNT_W-1:0] periodCount,
  input logic             timeoutPulse,
  input logic             irq
);
  assert_mask_reserved_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busAddr |-> busRdata[3:2] == 2'b00);

  assert_flag_low_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    busAddr |-> busRdata[3:0] == 4'h0);

  assert_flag_clear_only_by_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagBits[6]) |-> $past(busSel && busWr && busAddr && busWdata[6]));

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(timeoutPulse) |-> flagBits[6]);

  assert_hold_without_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(tickEn) |-> $stable(periodCount));

  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flagBits[7:4] == 4'h0) |-> !irq);
endmodule

bind pit_top pit_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel), .busWr(busWr),
  .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
  .flagBits(flagBits), .periodCount(periodCount),
  .timeoutPulse(timeoutPulse), .irq(irq)
);

// File: tb/pit_top_tb_top.sv
module pit_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic       busAddr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       ovfSet = 1'b0;
  logic       accOvfSet = 1'b0;
  logic       accEdgeSet = 1'b0;
  logic       irq;

  int compared = 0;
  int mismatched = 0;
  int ticks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) if (rstN && tickEn) ticks <= ticks + 1;

  pit_top dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .ovfSet(ovfSet), .accOvfSet(accOvfSet), .accEdgeSet(accEdgeSet), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at tick %0d", req, act, exp, ticks);
    end
  endtask

  task automatic readReg(input logic addr, output logic [7:0] val);
    busAddr = addr;
    #1;
    val = busRdata;
  endtask

  task automatic checkReg(input string req, input logic addr, input logic [7:0] exp);
    logic [7:0] v;
    readReg(addr, v);
    check(req, v, exp);
  endtask

  task automatic writeReg(input logic addr, input logic [7:0] data);
    busSel = 1'b1; busWr = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = 8'h00;
  endtask

  task automatic doReset();
    @(negedge clk);
    tickEn = 1'b0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    ticks = 0;
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitTick(input int n);
    while (ticks < n) @(negedge clk);
  endtask

  task automatic testReset();
    doReset();
    checkReg("R2 mask", 1'b0, 8'h00);
    checkReg("R2 flags", 1'b1, 8'h00);
    check("R2 irq", {7'b0, irq}, 8'h00);
  endtask

  task automatic testMaskReg();
    writeReg(1'b0, 8'hFF);
    checkReg("R1 reserved bits", 1'b0, 8'hF3);
    writeReg(1'b0, 8'h5A);
    checkReg("R1 pattern", 1'b0, 8'h52);
    writeReg(1'b0, 8'h00);
    checkReg("R1 cleared", 1'b0, 8'h00);
  endtask

  task automatic pulseOne(input int which);
    case (which)
      0: ovfSet = 1'b1;
      1: accOvfSet = 1'b1;
      default: accEdgeSet = 1'b1;
    endcase
    @(negedge clk);
    ovfSet = 1'b0; accOvfSet = 1'b0; accEdgeSet = 1'b0;
  endtask

  task automatic testExternalFlags();
    pulseOne(0);
    checkReg("R8 overflow flag", 1'b1, 8'h80);
    check("R9 masked off", {7'b0, irq}, 8'h00);
    writeReg(1'b0, 8'h80);
    check("R9 enabled", {7'b0, irq}, 8'h01);
    writeReg(1'b1, 8'h0F);
    checkReg("R7 zero write keeps", 1'b1, 8'h80);
    writeReg(1'b1, 8'h80);
    checkReg("R7 clear", 1'b1, 8'h00);
    check("R9 cleared", {7'b0, irq}, 8'h00);
    pulseOne(1);
    pulseOne(2);
    checkReg("R8 acc flags", 1'b1, 8'h30);
    check("R9 other bit not enabled", {7'b0, irq}, 8'h00);
    writeReg(1'b0, 8'h10);
    check("R9 edge enabled", {7'b0, irq}, 8'h01);
    writeReg(1'b1, 8'h10);
    checkReg("R7 partial clear", 1'b1, 8'h20);
    check("R9 after partial", {7'b0, irq}, 8'h00);
  endtask

  task automatic testPeriodic();
    doReset();
    tickEn = 1'b1;
    waitTick(8191);
    checkReg("R3 before period", 1'b1, 8'h00);
    waitTick(8192);
    checkReg("R3 first timeout", 1'b1, 8'h40);
    check("R6 no irq while disabled", {7'b0, irq}, 8'h00);
    writeReg(1'b0, 8'h40);
    check("R9 rti irq", {7'b0, irq}, 8'h01);
    waitTick(8300);
    writeReg(1'b1, 8'h40);
    checkReg("R4 cleared late", 1'b1, 8'h00);
    waitTick(16383);
    checkReg("R4 before second", 1'b1, 8'h00);
    waitTick(16384);
    checkReg("R4 second timeout", 1'b1, 8'h40);
    waitTick(16400);
    writeReg(1'b1, 8'h40);
    waitTick(24575);
    writeReg(1'b1, 8'h40);
    checkReg("R10 set wins", 1'b1, 8'h40);
    writeReg(1'b1, 8'h40);
    checkReg("R10 later clear", 1'b1, 8'h00);
  endtask

  task automatic testGapTicks();
    doReset();
    tickEn = 1'b1;
    waitTick(4000);
    tickEn = 1'b0;
    repeat (3000) @(negedge clk);
    checkReg("R5 no timeout in gap", 1'b1, 8'h00);
    tickEn = 1'b1;
    waitTick(8191);
    checkReg("R5 before period", 1'b1, 8'h00);
    waitTick(8192);
    checkReg("R5 timeout on tick count", 1'b1, 8'h40);
  endtask

  task automatic testRate(input logic [1:0] rate);
    int period;
    period = 8192 << rate;
    doReset();
    writeReg(1'b0, {6'b0, rate});
    tickEn = 1'b1;
    waitTick(period - 1);
    checkReg("R11 before period", 1'b1, 8'h00);
    waitTick(period);
    checkReg("R11 at period", 1'b1, 8'h40);
  endtask

  initial begin
    testReset();
    testMaskReg();
    testExternalFlags();
    testPeriodic();
    testGapTicks();
    testRate(2'd1);
    testRate(2'd2);
    testRate(2'd3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule